// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block is the processor-facing register file of a low-speed USB function. It holds one register with the device address and an enable bit, and one count/status register for each endpoint. Firmware reaches them over a byte-wide bus with an address, a write strobe and a read strobe. The read data is combinational and is valid while the read strobe is high.

The serial engine reports each finished OUT or SETUP transaction with a per-endpoint strobe. The strobe carries the toggle it received, a flag that is clear on any CRC, bit-stuff or PID error, and the received byte count, which includes the two CRC bytes. The block outputs the address to match, gated by the enable bit, and a transceiver power-down control. For each endpoint it also outputs the toggle and count that the next IN packet will use.

Endpoint 0 protects a freshly posted result. After a hardware update, firmware writes to that register are dropped until firmware has read it once.

Top module: `usb_ep_regbank`

## Requirements
- R1: After reset every register reads 0x00. `dev_addr` is 0, `addr_enable` is 0, `xcvr_pd` is 1, `in_toggle` and `in_count` are 0, and `cnt_err` is 0.
- R2: A write to offset 0x40 stores bit 7 as the enable and bits 6:0 as the device address. A read of 0x40 returns the stored byte. `dev_addr` shows the address only while the enable is 1 and is 0 otherwise. `xcvr_pd` is the inverse of the enable.
- R3: Endpoint n (n = 0, 1, 2) has its register at offset 0x41 + 2n. It holds the toggle in bit 7 (0 = DATA0, 1 = DATA1), the valid flag in bit 6 and the byte count in bits 3:0. A CPU write stores those bits. Bits 5:4 always read 0.
- R4: When `sie_done[n]` is high on a clock edge, register n takes toggle = `sie_toggle[n]`, valid = `sie_ok[n]` and count = `sie_count[4n+3:4n]`. If a CPU write to the same register falls in that cycle, the hardware values are stored.
- R5: A hardware update of endpoint 0 locks its register. While it is locked, CPU writes to 0x41 have no effect. A read of 0x41 in a cycle without a new endpoint 0 update clears the lock at that edge. Endpoints 1 and 2 never lock.
- R6: A read of any offset other than 0x40, 0x41, 0x43 and 0x45 returns 0x00, and a write to such an offset changes nothing. `cpu_rdata` is 0x00 whenever `cpu_rd` is low.
- R7: A reported count outside 2..10 is still stored unchanged. `cnt_err` is high for exactly the cycle after each edge at which such a report was taken.
- R8: `in_toggle[n]` and `in_count[4n+3:4n]` always equal the toggle and count fields of register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data, combinational |
| sie_done | input | 3 | Per-endpoint OUT/SETUP completion strobe |
| sie_toggle | input | 3 | Received data toggle per endpoint |
| sie_ok | input | 3 | Received packet free of errors, per endpoint |
| sie_count | input | 12 | Received byte count incl. CRC, 4 bits per endpoint |
| dev_addr | output | 7 | Address to match, 0 while disabled |
| addr_enable | output | 1 | Address recognition enabled |
| xcvr_pd | output | 1 | Transceiver power-down request |
| in_toggle | output | 3 | IN toggle per endpoint |
| in_count | output | 12 | IN byte count, 4 bits per endpoint |
| cnt_err | output | 1 | One-cycle pulse on an out-of-range reported count |

## Verification
`cpu_rdata` depends on the current inputs and state with no register in between. It is therefore compared in the same cycle the read strobe is applied, shortly after the inputs settle and before the edge. A write, a completion strobe or a lock change is visible on the register outputs one edge later. `cnt_err` is also one edge later, because it passes through one register. The bench drives stimulus on the falling edge and samples `cpu_rdata` one time unit later. It advances its behavioural model at the rising edge and compares every registered output at the following falling edge. This makes each result due exactly one cycle after the stimulus.

// File: rtl/usb_regbank_pkg.sv
package usb_regbank_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   typedef struct packed {
      logic             tog;
      logic             vld;
      logic [1:0]       rsv;
      logic [CNT_W-1:0] cnt;
   } ep_reg_t;

   typedef struct packed {
      logic       en;
      logic [6:0] addr;
   } addr_reg_t;

   function automatic ep_reg_t ep_from_cpu(input logic [BYTE_W-1:0] d);
      ep_reg_t r;
      r.tog = d[7];
      r.vld = d[6];
      r.rsv = 2'b00;
      r.cnt = d[CNT_W-1:0];
      return r;
   endfunction

endpackage

// File: rtl/usb_reg_decode.sv
module usb_reg_decode #(
   parameter int NUM_EP    = 3,
   parameter int BASE_ADDR = 'h40,
   parameter int EP_STRIDE = 2
) (
   input  logic [7:0]        addr,
   input  logic              wr,
   input  logic              rd,
   output logic              ctl_wr,
   output logic              ctl_rd,
   output logic [NUM_EP-1:0] ep_wr,
   output logic [NUM_EP-1:0] ep_rd
);
   localparam logic [7:0] CTL_OFS = 8'(BASE_ADDR);

   assign ctl_wr = wr && (addr == CTL_OFS);
   assign ctl_rd = rd && (addr == CTL_OFS);

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep_dec
      localparam logic [7:0] EP_OFS = 8'(BASE_ADDR + 1 + EP_STRIDE * i);
      assign ep_wr[i] = wr && (addr == EP_OFS);
      assign ep_rd[i] = rd && (addr == EP_OFS);
   end
endmodule

// File: rtl/usb_ep_cnt_reg.sv
module usb_ep_cnt_reg
   import usb_regbank_pkg::*;
#(
   parameter bit LOCKABLE = 1'b0,
   parameter int MIN_RX   = 2,
   parameter int MAX_RX   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              rd_hit,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              hw_done,
   input  logic              hw_tog,
   input  logic              hw_ok,
   input  logic [CNT_W-1:0]  hw_cnt,
   output ep_reg_t           q,
   output logic              locked,
   output logic              range_bad
);
   localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_RX);
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_RX);

   ep_reg_t hw_val;

   always_comb begin
      hw_val.tog = hw_tog;
      hw_val.vld = hw_ok;
      hw_val.rsv = 2'b00;
      hw_val.cnt = hw_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (hw_done)
         q <= hw_val;
      else if (wr_hit && !locked)
         q <= ep_from_cpu(wdata);
   end

   if (LOCKABLE) begin : g_lock
      logic lock_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lock_q <= 1'b0;
         else if (hw_done)
            lock_q <= 1'b1;
         else if (rd_hit)
            lock_q <= 1'b0;
      end
      assign locked = lock_q;
   end else begin : g_nolock
      assign locked = 1'b0;
   end

   assign range_bad = hw_done && ((hw_cnt < MIN_C) || (hw_cnt > MAX_C));
endmodule

// File: rtl/usb_rd_mux.sv
module usb_rd_mux
   import usb_regbank_pkg::*;
#(
   parameter int NUM_EP = 3
) (
   input  logic                     ctl_rd,
   input  logic [NUM_EP-1:0]        ep_rd,
   input  addr_reg_t                ctl_q,
   input  logic [NUM_EP*BYTE_W-1:0] ep_flat,
   output logic [BYTE_W-1:0]        rdata
);
   always_comb begin
      rdata = '0;
      if (ctl_rd)
         rdata = ctl_q;
      for (int i = 0; i < NUM_EP; i++)
         if (ep_rd[i])
            rdata = ep_flat[i*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
   import usb_regbank_pkg::*;
#(
   parameter int              NUM_EP      = 3,
   parameter int              BASE_ADDR   = 'h40,
   parameter int              EP_STRIDE   = 2,
   parameter int              MAX_PAYLOAD = 8,
   parameter int              CRC_BYTES   = 2,
   parameter logic [NUM_EP-1:0] LOCK_MASK = NUM_EP'(1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              cpu_addr,
   input  logic [7:0]              cpu_wdata,
   input  logic                    cpu_wr,
   input  logic                    cpu_rd,
   output logic [7:0]              cpu_rdata,
   input  logic [NUM_EP-1:0]       sie_done,
   input  logic [NUM_EP-1:0]       sie_toggle,
   input  logic [NUM_EP-1:0]       sie_ok,
   input  logic [NUM_EP*4-1:0]     sie_count,
   output logic [6:0]              dev_addr,
   output logic                    addr_enable,
   output logic                    xcvr_pd,
   output logic [NUM_EP-1:0]       in_toggle,
   output logic [NUM_EP*4-1:0]     in_count,
   output logic                    cnt_err
);
   localparam int MIN_RX   = CRC_BYTES;
   localparam int MAX_RX   = MAX_PAYLOAD + CRC_BYTES;
   localparam int LAST_OFS = BASE_ADDR + 1 + EP_STRIDE * (NUM_EP - 1);

   if (NUM_EP < 1)                  begin : g_chk_ep   $error("NUM_EP must be at least 1");          end
   if (EP_STRIDE < 1)               begin : g_chk_str  $error("EP_STRIDE must be at least 1");       end
   if (MAX_RX > (1 << CNT_W) - 1)   begin : g_chk_cnt  $error("count field too narrow for payload"); end
   if (LAST_OFS > 255)              begin : g_chk_map  $error("register map exceeds address space"); end

   logic                     ctl_wr, ctl_rd;
   logic [NUM_EP-1:0]        ep_wr, ep_rd, ep_lock, ep_bad;
   logic [NUM_EP*BYTE_W-1:0] ep_flat;
   addr_reg_t                ctl_q;
   logic                     err_q;

   usb_reg_decode #(
      .NUM_EP(NUM_EP), .BASE_ADDR(BASE_ADDR), .EP_STRIDE(EP_STRIDE)
   ) u_dec (
      .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd),
      .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ep_wr(ep_wr), .ep_rd(ep_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr)
         ctl_q <= cpu_wdata;
   end

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      ep_reg_t q;
      usb_ep_cnt_reg #(
         .LOCKABLE(LOCK_MASK[i]), .MIN_RX(MIN_RX), .MAX_RX(MAX_RX)
      ) u_reg (
         .clk(clk), .rst_n(rst_n),
         .wr_hit(ep_wr[i]), .rd_hit(ep_rd[i]), .wdata(cpu_wdata),
         .hw_done(sie_done[i]), .hw_tog(sie_toggle[i]), .hw_ok(sie_ok[i]),
         .hw_cnt(sie_count[i*CNT_W +: CNT_W]),
         .q(q), .locked(ep_lock[i]), .range_bad(ep_bad[i])
      );
      assign ep_flat[i*BYTE_W +: BYTE_W] = q;
      assign in_toggle[i]                = q.tog;
      assign in_count[i*CNT_W +: CNT_W]  = q.cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= |ep_bad;
   end

   usb_rd_mux #(.NUM_EP(NUM_EP)) u_mux (
      .ctl_rd(ctl_rd), .ep_rd(ep_rd), .ctl_q(ctl_q),
      .ep_flat(ep_flat), .rdata(cpu_rdata)
   );

   assign addr_enable = ctl_q.en;
   assign dev_addr    = ctl_q.en ? ctl_q.addr : 7'd0;
   assign xcvr_pd     = !ctl_q.en;
   assign cnt_err     = err_q;
endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk #(
   parameter int NUM_EP    = 3,
   parameter int BASE_ADDR = 'h40,
   parameter int EP_STRIDE = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          cpu_addr,
   input logic                cpu_wr,
   input logic                cpu_rd,
   input logic [7:0]          cpu_rdata,
   input logic [NUM_EP-1:0]   sie_done,
   input logic [NUM_EP-1:0]   sie_toggle,
   input logic [NUM_EP*4-1:0] sie_count,
   input logic [6:0]          dev_addr,
   input logic                xcvr_pd,
   input logic [NUM_EP-1:0]   in_toggle,
   input logic [NUM_EP*4-1:0] in_count,
   input logic                cnt_err,
   input logic [NUM_EP-1:0]   ep_lock
);
   localparam logic [7:0] EP0_OFS = 8'(BASE_ADDR + 1);

   logic mapped;
   always_comb begin
      mapped = (cpu_addr == 8'(BASE_ADDR));
      for (int i = 0; i < NUM_EP; i++)
         if (cpu_addr == 8'(BASE_ADDR + 1 + EP_STRIDE * i)) mapped = 1'b1;
   end

   p_pd_hides_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xcvr_pd |-> dev_addr == 7'd0);

   p_hw_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sie_done[0] |=> (in_toggle[0] == $past(sie_toggle[0]))
                   && (in_count[3:0] == $past(sie_count[3:0])));

   p_lock_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sie_done[0] |=> ep_lock[0]);

   p_locked_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_lock[0] && cpu_wr && cpu_addr == EP0_OFS && !sie_done[0])
      |=> $stable(in_count[3:0]) && $stable(in_toggle[0]));

   p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !mapped) |-> cpu_rdata == 8'h00);

   p_err_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_err |-> $past(|sie_done));
endmodule

bind usb_ep_regbank usb_ep_regbank_chk #(
   .NUM_EP(NUM_EP), .BASE_ADDR(BASE_ADDR), .EP_STRIDE(EP_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
   .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .sie_done(sie_done),
   .sie_toggle(sie_toggle), .sie_count(sie_count), .dev_addr(dev_addr),
   .xcvr_pd(xcvr_pd), .in_toggle(in_toggle), .in_count(in_count),
   .cnt_err(cnt_err), .ep_lock(ep_lock)
);

// File: tb/test_usb_ep_regbank.sv
module test_usb_ep_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int NEP        = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  cpu_addr, cpu_wdata, cpu_rdata;
   logic        cpu_wr, cpu_rd;
   logic [2:0]  sie_done, sie_toggle, sie_ok;
   logic [11:0] sie_count;
   logic [6:0]  dev_addr;
   logic        addr_enable, xcvr_pd, cnt_err;
   logic [2:0]  in_toggle;
   logic [11:0] in_count;

   int compared   = 0;
   int mismatched = 0;
   int cycles     = 0;

   // behavioural model state
   logic [7:0] m_ctl;
   logic [7:0] m_ep [NEP];
   bit         m_lock;
   bit         m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_ep_regbank i_usb_ep_regbank (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
      .sie_done(sie_done), .sie_toggle(sie_toggle), .sie_ok(sie_ok),
      .sie_count(sie_count), .dev_addr(dev_addr), .addr_enable(addr_enable),
      .xcvr_pd(xcvr_pd), .in_toggle(in_toggle), .in_count(in_count),
      .cnt_err(cnt_err)
   );

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int ep_index(input logic [7:0] a);
      for (int i = 0; i < NEP; i++)
         if (a == 8'(8'h41 + 2*i)) return i;
      return -1;
   endfunction

   function automatic logic [7:0] model_rdata();
      int e;
      if (!cpu_rd) return 8'h00;
      if (cpu_addr == 8'h40) return m_ctl;
      e = ep_index(cpu_addr);
      if (e >= 0) return m_ep[e];
      return 8'h00;
   endfunction

   task automatic model_edge();
      int  e;
      bit  bad;
      if (!rst_n) begin
         m_ctl = 0; m_lock = 0; m_err = 0;
         for (int i = 0; i < NEP; i++) m_ep[i] = 0;
         return;
      end
      e   = cpu_wr ? ep_index(cpu_addr) : -1;
      bad = 0;
      if (cpu_wr && cpu_addr == 8'h40) m_ctl = cpu_wdata;
      for (int i = 0; i < NEP; i++) begin
         if (sie_done[i]) begin
            int c;
            c = int'(sie_count[i*4 +: 4]);
            m_ep[i] = {sie_toggle[i], sie_ok[i], 2'b00, sie_count[i*4 +: 4]};
            if (c < 2 || c > 10) bad = 1;
         end else if (e == i && !(i == 0 && m_lock)) begin
            m_ep[i] = cpu_wdata & 8'hCF;
         end
      end
      if (sie_done[0]) m_lock = 1;
      else if (cpu_rd && cpu_addr == 8'h41) m_lock = 0;
      m_err = bad;
   endtask

   task automatic compare_regs();
      check("R2", "dev_addr", dev_addr, m_ctl[7] ? m_ctl[6:0] : 0);
      check("R2", "addr_enable", addr_enable, m_ctl[7]);
      check("R2", "xcvr_pd", xcvr_pd, !m_ctl[7]);
      for (int i = 0; i < NEP; i++) begin
         check("R8", $sformatf("in_toggle[%0d]", i), in_toggle[i], m_ep[i][7]);
         check("R8", $sformatf("in_count[%0d]", i), in_count[i*4 +: 4], m_ep[i][3:0]);
      end
      check("R7", "cnt_err", cnt_err, m_err);
   endtask

   // one clock: drive at falling edge, read data checked before rising edge,
   // registered outputs checked at next falling edge
   task automatic step(input logic [7:0] a, input logic [7:0] d,
                       input bit wr, input bit rd,
                       input logic [2:0] dn, input logic [2:0] tg,
                       input logic [2:0] ok, input logic [11:0] cn);
      string tag;
      cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = rd;
      sie_done = dn; sie_toggle = tg; sie_ok = ok; sie_count = cn;
      #1;
      tag = (a == 8'h40) ? "R2" : (ep_index(a) >= 0 ? "R3" : "R6");
      check(tag, "cpu_rdata", cpu_rdata, model_rdata());
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_regs();
   endtask

   task automatic wr8(input logic [7:0] a, input logic [7:0] d);
      step(a, d, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic rd8(input logic [7:0] a, input logic [7:0] exp, input string req);
      cpu_addr = a; cpu_wr = 0; cpu_rd = 1; sie_done = 0;
      #1;
      check(req, $sformatf("read 0x%0h", a), cpu_rdata, exp);
      step(a, 0, 0, 1, 0, 0, 0, 0);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      rst_n = 0;
      cpu_addr = 0; cpu_wdata = 0; cpu_wr = 0; cpu_rd = 0;
      sie_done = 0; sie_toggle = 0; sie_ok = 0; sie_count = 0;
      repeat (3) @(posedge clk);
      model_edge();
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check("R1", "xcvr_pd", xcvr_pd, 1);
      check("R1", "dev_addr", dev_addr, 0);
      check("R1", "in_count", in_count, 0);
      check("R1", "cnt_err", cnt_err, 0);
      rd8(8'h41, 8'h00, "R1");
      rd8(8'h40, 8'h00, "R1");

      // R2 address and enable
      wr8(8'h40, 8'h85);
      check("R2", "dev_addr enabled", dev_addr, 7'h05);
      check("R2", "xcvr_pd enabled", xcvr_pd, 0);
      wr8(8'h40, 8'h2A);
      check("R2", "dev_addr disabled", dev_addr, 0);
      rd8(8'h40, 8'h2A, "R2");

      // R3 endpoint write, reserved bits
      wr8(8'h43, 8'hFF);
      rd8(8'h43, 8'hCF, "R3");
      wr8(8'h45, 8'h88);
      check("R8", "in_count ep2", in_count[11:8], 4'h8);

      // R6 unmapped accesses
      wr8(8'h42, 8'hFF);
      wr8(8'h00, 8'hFF);
      rd8(8'h42, 8'h00, "R6");
      rd8(8'h47, 8'h00, "R6");
      rd8(8'h40, 8'h2A, "R6");

      // R4 completion on endpoint 0, then R5 lock
      step(0, 0, 0, 0, 3'b001, 3'b001, 3'b001, 12'h00A);
      check("R4", "ep0 toggle", in_toggle[0], 1);
      check("R4", "ep0 count", in_count[3:0], 4'hA);
      wr8(8'h41, 8'h03);
      check("R5", "locked write ignored", in_count[3:0], 4'hA);
      rd8(8'h41, 8'hCA, "R5");
      wr8(8'h41, 8'h03);
      check("R5", "write after read", in_count[3:0], 4'h3);
      // endpoint 1 never locks
      step(0, 0, 0, 0, 3'b010, 3'b000, 3'b010, 12'h040);
      wr8(8'h43, 8'h06);
      check("R5", "ep1 unlocked", in_count[7:4], 4'h6);

      // R4 hardware wins over same-cycle write
      step(8'h45, 8'h05, 1, 0, 3'b100, 3'b100, 3'b000, 12'h700);
      rd8(8'h45, 8'h87, "R4");

      // R7 out-of-range count stored, one-cycle pulse
      step(0, 0, 0, 0, 3'b010, 3'b000, 3'b010, 12'h0C0);
      check("R7", "err pulse", cnt_err, 1);
      check("R7", "count stored", in_count[7:4], 4'hC);
      idle();
      check("R7", "err cleared", cnt_err, 0);
      step(0, 0, 0, 0, 3'b100, 3'b000, 3'b000, 12'h100);
      check("R7", "count 1 low", cnt_err, 1);

      // mixed traffic against the model
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         logic [2:0] dn;
         case ($urandom_range(0, 8))
            0: a = 8'h40; 1, 2: a = 8'h41; 3: a = 8'h43; 4: a = 8'h45;
            5: a = 8'h42; 6: a = 8'h44; 7: a = 8'h46; default: a = 8'h7F;
         endcase
         dn = 3'($urandom) & 3'($urandom) & 3'($urandom);
         step(a, 8'($urandom), 1'($urandom), 1'($urandom), dn,
              3'($urandom), 3'($urandom), 12'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule